// File: doc/BRIEF.md
# Dual-Read Single-Write Memory with Collision and Bypass Tracking

This block is a synchronous storage array with one write port and two independent read ports. Every access takes one clock: the address and enables are presented in cycle N and the read data, a per-port valid flag and a two-bit severity code appear in cycle N+1. The two read ports may address the same word in the same cycle and both return the stored contents.

The block also reports accesses that must not be relied on. If one port reads a word that is being written in the same cycle, the new data still goes into the array. That port's result is treated as undefined: its valid flag drops, its data is forced to zero, and the severity output reports a forbidden access.

A transparent bypass input, used while the chip is under scan test, routes the write data straight to both read outputs and leaves the array untouched. Because the array contents cannot be trusted after a scan shift, every word is marked lost during bypass. A later read of a lost word returns invalid and is reported as forbidden. A read of a word never written since reset is reported as a warning. Writing a word makes it valid again.

Top module: `twin_read_ram`

## Requirements
- R1: In normal mode (bypass low), a write with `wr_en` high stores `wr_data` at `wr_addr`. A later read of that word returns the data one cycle after the read request, with its valid flag high.
- R2: A read port whose enable is low in a normal-mode cycle shows its valid flag low in the following cycle.
- R3: When a read port addresses the same word that is written in the same normal-mode cycle, that port's next-cycle valid flag is low and its data is zero. The array still takes the new write data, so a later read returns it.
- R4: Such a same-cycle read/write collision on either port makes the next-cycle severity 2'b10 (forbidden).
- R5: Two reads in one cycle, at the same or different addresses and with no colliding write, both return the stored (old) data with valid high. The next-cycle severity is 2'b00 (allowed) when both words hold valid data.
- R6: In a bypass cycle, each read port presents that cycle's `wr_data` in the next cycle with valid high, and the severity is 2'b00. The array is not written.
- R7: A bypass cycle marks every word lost. An enabled read of a lost word that has not been rewritten gives valid low and severity 2'b10.
- R8: An enabled read of a word that has not been written since reset and was not lost to bypass gives valid low and severity 2'b01 (warning).
- R9: After reset, both valid flags are low, the severity is 2'b00, and every word counts as never written.
- R10: The severity is the highest of the two ports' conditions, with forbidden above warning above allowed. The code 2'b11 never appears.
- R11: Writing a lost word in normal mode makes it valid again: a later read returns the new data with valid high and severity 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | Scan-test transparent mode |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | ADDR_W | Read port 0 address |
| rd0_data | output | DATA_W | Read port 0 data, registered |
| rd0_valid | output | 1 | Read port 0 data is trustworthy |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | ADDR_W | Read port 1 address |
| rd1_data | output | DATA_W | Read port 1 data, registered |
| rd1_valid | output | 1 | Read port 1 data is trustworthy |
| severity | output | 2 | 00 allowed, 01 warning, 10 forbidden; registered with the read data |

## Verification
On every cycle the assertions check the one-cycle consequences of the inputs. A collision drops that port's valid flag, zeroes its data and raises forbidden severity. Bypass passes the write data through, reports allowed and wipes every word's validity. A disabled port reports invalid, and a normal write marks its word valid. The bench scenarios are needed for effects that span many cycles: data written earlier coming back on both ports, a collided write actually landing in the array, a lost word staying forbidden until it is rewritten, and the ranking of a warning on one port against a forbidden access on the other.

// File: rtl/twin_read_pkg.sv
// Shared definitions for the dual-read single-write memory.
// Assumes exactly two read ports; the severity code is ordered so that a
// numerically larger value is the more serious condition.
package twin_read_pkg;

    localparam int NUM_RD = 2;

    typedef enum logic [1:0] {
        SEV_ALLOWED   = 2'b00,
        SEV_WARNING   = 2'b01,
        SEV_FORBIDDEN = 2'b10
    } sev_t;

    // Pick the more serious of two severity codes.
    function automatic sev_t sev_worst(input sev_t a, input sev_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/twin_read_array.sv
// Storage array: one synchronous write port and NUM_RD combinational read
// taps. The read taps are registered by the port logic downstream.
// Assumes the caller blocks writes while bypass is active.
module twin_read_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NRD    = 2
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] tap_addr [NRD],
    output logic [DATA_W-1:0] tap_data [NRD]
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit the write word at the clock edge.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // One combinational tap per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_tap
        assign tap_data[p] = cells[tap_addr[p]];
    end

endmodule

// File: rtl/twin_read_word_state.sv
// Per-word validity bookkeeping: a written bit and a lost bit per word.
// A bypass cycle marks every word lost and unwritten. A normal write marks
// its word written and not lost. Reset leaves every word unwritten, not lost.
module twin_read_word_state #(
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bypass,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    output logic [(1<<ADDR_W)-1:0]   word_ok,
    output logic [(1<<ADDR_W)-1:0]   word_lost
);
    localparam int DEPTH = 1 << ADDR_W;

    // Update the validity and loss maps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_ok   <= '0;
            word_lost <= '0;
        end else if (bypass) begin
            word_ok   <= '0;
            word_lost <= {DEPTH{1'b1}};
        end else if (wr_en) begin
            word_ok[wr_addr]   <= 1'b1;
            word_lost[wr_addr] <= 1'b0;
        end
    end

    AST_BYPASS_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (word_ok == '0) && (word_lost == {DEPTH{1'b1}})); // R7

    AST_WRITE_MARKS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && wr_en) |=> word_ok[$past(wr_addr)] && !word_lost[$past(wr_addr)]); // R11

endmodule

// File: rtl/twin_read_port.sv
// One registered read port. It detects a same-address write in the same
// cycle, decides the valid flag and returns this port's severity
// contribution. In bypass it forwards the write data.
// Assumes the array tap shows pre-write contents during the cycle.
module twin_read_port
    import twin_read_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bypass,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [DATA_W-1:0]        tap_data,
    input  logic [(1<<ADDR_W)-1:0]   word_ok,
    input  logic [(1<<ADDR_W)-1:0]   word_lost,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output sev_t                     port_sev
);
    logic clash;
    logic hit_ok;
    logic hit_lost;

    // Same-cycle write/read address match and word state lookup.
    always_comb begin
        clash    = wr_en && rd_en && (wr_addr == rd_addr);
        hit_ok   = word_ok[rd_addr];
        hit_lost = word_lost[rd_addr];
    end

    // Severity contribution of this port for the current request.
    always_comb begin
        if (bypass || !rd_en) begin
            port_sev = SEV_ALLOWED;
        end else if (clash || hit_lost) begin
            port_sev = SEV_FORBIDDEN;
        end else if (!hit_ok) begin
            port_sev = SEV_WARNING;
        end else begin
            port_sev = SEV_ALLOWED;
        end
    end

    // Output data and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (bypass) begin
            rd_data  <= wr_data;
            rd_valid <= 1'b1;
        end else if (rd_en) begin
            rd_data  <= clash ? '0 : tap_data;
            rd_valid <= hit_ok && !clash;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    AST_CLASH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && wr_en && rd_en && wr_addr == rd_addr) |=> !rd_valid && (rd_data == '0)); // R3

    AST_BYPASS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> rd_valid && (rd_data == $past(wr_data))); // R6

    AST_IDLE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !rd_en) |=> !rd_valid); // R2

endmodule

// File: rtl/twin_read_ram.sv
// Top: dual-read single-write memory with collision, bypass and severity
// reporting. All results are registered one cycle after the request.
// Assumes a synchronous active-low reset held for at least one clock edge.
module twin_read_ram
    import twin_read_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd0_en,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_valid,
    input  logic              rd1_en,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_valid,
    output logic [1:0]        severity
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              p_en    [NUM_RD];
    logic [ADDR_W-1:0] p_addr  [NUM_RD];
    logic [DATA_W-1:0] p_tap   [NUM_RD];
    logic [DATA_W-1:0] p_data  [NUM_RD];
    logic              p_valid [NUM_RD];
    sev_t              p_sev   [NUM_RD];
    logic [DEPTH-1:0]  word_ok;
    logic [DEPTH-1:0]  word_lost;
    sev_t              sev_next;
    sev_t              sev_q;

    // Gather the flat port pins into per-port arrays.
    always_comb begin
        p_en[0]   = rd0_en;
        p_addr[0] = rd0_addr;
        p_en[1]   = rd1_en;
        p_addr[1] = rd1_addr;
    end

    twin_read_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NRD    (NUM_RD)
    ) u_array (
        .clk      (clk),
        .wr_go    (wr_en && !bypass),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tap_addr (p_addr),
        .tap_data (p_tap)
    );

    twin_read_word_state #(
        .ADDR_W (ADDR_W)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass    (bypass),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .word_ok   (word_ok),
        .word_lost (word_lost)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        twin_read_port #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .bypass    (bypass),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .rd_en     (p_en[p]),
            .rd_addr   (p_addr[p]),
            .tap_data  (p_tap[p]),
            .word_ok   (word_ok),
            .word_lost (word_lost),
            .rd_data   (p_data[p]),
            .rd_valid  (p_valid[p]),
            .port_sev  (p_sev[p])
        );
    end

    // Rank the port contributions: the most serious one wins.
    always_comb begin
        sev_next = SEV_ALLOWED;
        for (int p = 0; p < NUM_RD; p++) begin
            sev_next = sev_worst(sev_next, p_sev[p]);
        end
    end

    // Register the severity alongside the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sev_q <= SEV_ALLOWED;
        end else begin
            sev_q <= sev_next;
        end
    end

    assign rd0_data  = p_data[0];
    assign rd0_valid = p_valid[0];
    assign rd1_data  = p_data[1];
    assign rd1_valid = p_valid[1];
    assign severity  = sev_q;

    AST_CLASH_FORBIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && wr_en && ((rd0_en && rd0_addr == wr_addr) || (rd1_en && rd1_addr == wr_addr)))
        |=> severity == 2'b10); // R4

    AST_BYPASS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> severity == 2'b00); // R6

    AST_LOST_FORBIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && rd0_en && word_lost[rd0_addr]) |=> (severity == 2'b10) && !rd0_valid); // R7

    AST_UNWRITTEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && rd1_en && !word_ok[rd1_addr]) |=> !rd1_valid && (severity != 2'b00)); // R8

endmodule

// File: tb/twin_read_ram_tb.sv
`timescale 1ns/1ps
module twin_read_ram_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bypass = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd0_en = 1'b0;
    logic [AW-1:0] rd0_addr = '0;
    logic [DW-1:0] rd0_data;
    logic          rd0_valid;
    logic          rd1_en = 1'b0;
    logic [AW-1:0] rd1_addr = '0;
    logic [DW-1:0] rd1_data;
    logic          rd1_valid;
    logic [1:0]    severity;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] m_data [DEPTH];
    bit            m_ok   [DEPTH];
    bit            m_lost [DEPTH];

    always #2.5 clk = ~clk;

    twin_read_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd0_valid(rd0_valid),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rd1_valid(rd1_valid),
        .severity(severity)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bypass = 1'b0; wr_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R9 rd0_valid", int'(rd0_valid), 0);
        chk("R9 rd1_valid", int'(rd1_valid), 0);
        chk("R9 severity", int'(severity), 0);
        for (int i = 0; i < DEPTH; i++) begin
            m_ok[i] = 1'b0;
            m_lost[i] = 1'b0;
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Expected result of one read port, from the requirement rules.
    task automatic port_exp(input bit byp, input bit wen, input int wa, input int wd,
                            input bit en, input int a, output bit ev, output int ed,
                            output bit dchk, output int es);
        bit col;
        col  = wen && en && (a == wa);
        ev   = 1'b0; ed = 0; dchk = 1'b0; es = 0;
        if (byp) begin
            ev = 1'b1; ed = wd; dchk = 1'b1;
        end else if (en) begin
            ev = m_ok[a] && !col;
            if (col) begin
                ed = 0; dchk = 1'b1; es = 2;
            end else begin
                ed = int'(m_data[a]); dchk = ev;
                es = m_lost[a] ? 2 : (m_ok[a] ? 0 : 1);
            end
        end
    endtask

    task automatic step(input string tag, input bit byp, input bit wen, input int wa,
                        input int wd, input bit e0, input int a0, input bit e1, input int a1);
        bit ev0, ev1, dc0, dc1;
        int ed0, ed1, es0, es1, es;
        @(negedge clk);
        bypass = byp; wr_en = wen; wr_addr = AW'(wa); wr_data = DW'(wd);
        rd0_en = e0; rd0_addr = AW'(a0); rd1_en = e1; rd1_addr = AW'(a1);
        port_exp(byp, wen, wa, wd, e0, a0, ev0, ed0, dc0, es0);
        port_exp(byp, wen, wa, wd, e1, a1, ev1, ed1, dc1, es1);
        es = (es0 > es1) ? es0 : es1;
        @(posedge clk);
        #1;
        chk({tag, " rd0_valid"}, int'(rd0_valid), int'(ev0));
        chk({tag, " rd1_valid"}, int'(rd1_valid), int'(ev1));
        if (dc0) chk({tag, " rd0_data"}, int'(rd0_data), ed0);
        if (dc1) chk({tag, " rd1_data"}, int'(rd1_data), ed1);
        chk({tag, " severity"}, int'(severity), es);
        if (byp) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_ok[i] = 1'b0;
                m_lost[i] = 1'b1;
            end
        end else if (wen) begin
            m_data[wa] = DW'(wd);
            m_ok[wa] = 1'b1;
            m_lost[wa] = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8: every word unwritten after reset, both ports
        for (int a = 0; a < DEPTH; a++) step("R8", 0, 0, 0, 0, 1, a, 1, DEPTH - 1 - a);
        // R1 fill, with R2 idle ports
        for (int a = 0; a < DEPTH; a++) step("R1 R2", 0, 1, a, (a * 37 + 5) & 255, 0, 0, 0, 0);
        // R5 / R1: all address pairs on the two ports
        for (int a = 0; a < DEPTH; a++)
            for (int k = 0; k < DEPTH; k++)
                step("R5", 0, 0, 0, 0, 1, a, 1, (a + k) % DEPTH);
        // R3 / R4: collisions on port 0, then on port 1, then readback
        for (int a = 0; a < DEPTH; a++)
            step("R3 R4 p0", 0, 1, a, (a * 11 + 200) & 255, 1, a, 1, (a + 1) % DEPTH);
        for (int a = 0; a < DEPTH; a++)
            step("R3 R4 p1", 0, 1, a, (a * 13 + 90) & 255, 1, (a + 3) % DEPTH, 1, a);
        for (int a = 0; a < DEPTH; a++) step("R3 readback", 0, 0, 0, 0, 1, a, 1, a);
        // R1: write to one word while reading a different one
        step("R1 distinct", 0, 1, 2, 77, 1, 3, 1, 4);
        step("R1 readback", 0, 0, 0, 0, 1, 2, 0, 0);
        // R6: bypass forwarding with varying data
        for (int i = 0; i < 6; i++) step("R6", 1, i % 2, i, (i * 41 + 3) & 255, i % 3 == 0, i, 1, i + 1);
        // R7: every word lost
        for (int a = 0; a < DEPTH; a++) step("R7", 0, 0, 0, 0, 1, a, 0, 0);
        // R11: rewrite some lost words then read them
        for (int a = 0; a < DEPTH; a += 3) step("R11 write", 0, 1, a, (a * 5 + 1) & 255, 0, 0, 0, 0);
        for (int a = 0; a < DEPTH; a++) step("R11 R7", 0, 0, 0, 0, 1, a, 1, (a + 3) % DEPTH);
        // R10: warning on one port against forbidden on the other
        do_reset();
        step("R10 prep", 0, 1, 1, 19, 0, 0, 0, 0);
        step("R10", 0, 1, 5, 44, 1, 3, 1, 5);
        step("R10 mix", 0, 0, 0, 0, 1, 7, 1, 1);
        step("R10 swap", 0, 1, 9, 66, 1, 9, 1, 12);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule